// File: doc/BRIEF.md
# Adder-Derived Bit-Slice ALU

This block is a small arithmetic and logic unit made of identical one-bit slices joined by a ripple carry. Every slice holds a single full adder. An XOR on the A input can invert that operand, and a multiplexer chooses the slice output from the adder's sum term, its majority (carry) term, operand B, the conditioned A bit or zero. The logic functions are not built from separate gates. AND and OR come from the majority term with the slice carry-in forced to 0 or to 1. XOR is the sum term with carry-in 0. Subtraction inverts A and forces the lowest carry-in to 1.

A 4-bit operation code is decoded into the slice controls. These controls are the A inversion, whether each slice takes the carry from the slice below or a forced constant, the forced carry value and the output selection. The width is a parameter with a default of 4. The result and the carry-out are registered on the rising clock edge, and a synchronous active-high reset clears both.

Top module: `alu_bs_top`

## Requirements
- R1: While rst is high at a rising clock edge, y and co are 0 after that edge.
- R2: y and co change only at a rising edge, and they reflect the a, b and op values sampled at that edge. This gives one cycle of latency.
- R3: op 4'b0000 gives y = a AND b, with co = 0.
- R4: op 4'b0001 gives y = a OR b, with co = 0.
- R5: op 4'b0010 gives y = a XOR b, with co = 0.
- R6: op 4'b0011 gives y = (a + b) mod 2^WIDTH, and co is bit WIDTH of the full sum.
- R7: op 4'b0100 gives y = (a + b + 1) mod 2^WIDTH, and co is bit WIDTH of a + b + 1.
- R8: op 4'b0101 gives y = (b - a) mod 2^WIDTH. co is 1 exactly when b >= a, so co is the carry of b + ~a + 1.
- R9: op 4'b0110 gives y = b, with co = 0.
- R10: op 4'b0111 gives y = NOT a, with co = 0.
- R11: op codes 4'b1000 to 4'b1111 give y = 0 and co = 0, whatever a and b are.
- R12: The carry ripples through every slice. With op 4'b0011, all-ones plus 1 gives y = 0 and co = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | Operand A (the operand that is inverted for subtraction) |
| b | input | WIDTH | Operand B |
| op | input | 4 | Operation code |
| y | output | WIDTH | Registered result |
| co | output | 1 | Registered carry-out, 0 for logic operations |

## Verification
Each result is due exactly one rising edge after its operands and code are presented. The bench drives the inputs on the falling edge and compares y and co shortly after the next rising edge. One directed check also reads the outputs just before that edge, to confirm that they still hold the previous result. The reset check holds an operation whose result would be nonzero, so a cleared output can only come from the reset.

// File: rtl/alu_bs_pkg.sv
package alu_bs_pkg;

  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_AND   = 4'b0000;
  localparam logic [OPW-1:0] OP_OR    = 4'b0001;
  localparam logic [OPW-1:0] OP_XOR   = 4'b0010;
  localparam logic [OPW-1:0] OP_ADD   = 4'b0011;
  localparam logic [OPW-1:0] OP_INC   = 4'b0100;
  localparam logic [OPW-1:0] OP_SUB   = 4'b0101;
  localparam logic [OPW-1:0] OP_PASSB = 4'b0110;
  localparam logic [OPW-1:0] OP_NOTA  = 4'b0111;

  typedef enum logic [2:0] {
    SEL_SUM   = 3'd0,
    SEL_MAJ   = 3'd1,
    SEL_PASSB = 3'd2,
    SEL_PASSA = 3'd3,
    SEL_ZERO  = 3'd4
  } out_sel_t;

  typedef struct packed {
    logic     inv_a;   // XOR condition on operand A
    logic     ripple;  // slices take carry from the slice below
    logic     cin_val; // forced carry value
    out_sel_t osel;    // slice output select
    logic     arith;   // carry-out is the ripple carry
  } slice_ctrl_t;

endpackage

// File: rtl/alu_bs_decode.sv
module alu_bs_decode
  import alu_bs_pkg::*;
(
  input  logic [OPW-1:0] op,
  output slice_ctrl_t    ctrl
);

  always_comb begin
    ctrl = '{inv_a: 1'b0, ripple: 1'b0, cin_val: 1'b0, osel: SEL_ZERO, arith: 1'b0};
    case (op)
      OP_AND:   ctrl.osel = SEL_MAJ;
      OP_OR: begin
        ctrl.osel    = SEL_MAJ;
        ctrl.cin_val = 1'b1;
      end
      OP_XOR:   ctrl.osel = SEL_SUM;
      OP_ADD: begin
        ctrl.osel   = SEL_SUM;
        ctrl.ripple = 1'b1;
        ctrl.arith  = 1'b1;
      end
      OP_INC: begin
        ctrl.osel    = SEL_SUM;
        ctrl.ripple  = 1'b1;
        ctrl.cin_val = 1'b1;
        ctrl.arith   = 1'b1;
      end
      OP_SUB: begin
        ctrl.osel    = SEL_SUM;
        ctrl.ripple  = 1'b1;
        ctrl.cin_val = 1'b1;
        ctrl.inv_a   = 1'b1;
        ctrl.arith   = 1'b1;
      end
      OP_PASSB: ctrl.osel = SEL_PASSB;
      OP_NOTA: begin
        ctrl.osel  = SEL_PASSA;
        ctrl.inv_a = 1'b1;
      end
      default:  ctrl.osel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/alu_bs_slice.sv
module alu_bs_slice
  import alu_bs_pkg::*;
(
  input  logic     a_bit,
  input  logic     b_bit,
  input  logic     carry_below,
  input  logic     inv_a,
  input  logic     ripple,
  input  logic     cin_val,
  input  out_sel_t osel,
  output logic     y_bit,
  output logic     carry_up
);

  logic a_c;
  logic cin_eff;
  logic sum_t;
  logic maj_t;

  always_comb begin
    a_c     = a_bit ^ inv_a;
    cin_eff = ripple ? carry_below : cin_val;
    sum_t   = a_c ^ b_bit ^ cin_eff;
    maj_t   = (a_c & b_bit) | (a_c & cin_eff) | (b_bit & cin_eff);
    case (osel)
      SEL_SUM:   y_bit = sum_t;
      SEL_MAJ:   y_bit = maj_t;
      SEL_PASSB: y_bit = b_bit;
      SEL_PASSA: y_bit = a_c;
      default:   y_bit = 1'b0;
    endcase
  end

  assign carry_up = maj_t;

endmodule

// File: rtl/alu_bs_top.sv
module alu_bs_top
  import alu_bs_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       op,
  output logic [WIDTH-1:0] y,
  output logic             co
);

  localparam int CHAIN = WIDTH + 1;

  slice_ctrl_t      ctrl;
  logic [CHAIN-1:0] chain;
  logic [WIDTH-1:0] res_c;
  logic             co_c;
  logic [WIDTH-1:0] y_q;
  logic             co_q;

  alu_bs_decode u_dec (
    .op   (op),
    .ctrl (ctrl)
  );

  assign chain[0] = ctrl.cin_val;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bs_slice u_slice (
      .a_bit       (a[i]),
      .b_bit       (b[i]),
      .carry_below (chain[i]),
      .inv_a       (ctrl.inv_a),
      .ripple      (ctrl.ripple),
      .cin_val     (ctrl.cin_val),
      .osel        (ctrl.osel),
      .y_bit       (res_c[i]),
      .carry_up    (chain[i+1])
    );
  end

  assign co_c = ctrl.arith & chain[WIDTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q  <= '0;
      co_q <= 1'b0;
    end else begin
      y_q  <= res_c;
      co_q <= co_c;
    end
  end

  assign y  = y_q;
  assign co = co_q;

  // R1
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (y == '0 && co == 1'b0));

  // R11
  p_unused_zero_r11: assert property (@(posedge clk) disable iff (rst)
    op[3] |=> (y == '0 && co == 1'b0));

  // R3 R4 R5 R9 R10
  p_logic_no_carry_r3: assert property (@(posedge clk) disable iff (rst)
    !(op == OP_ADD || op == OP_INC || op == OP_SUB) |=> (co == 1'b0));

  // R9
  p_passb_r9: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PASSB) |=> (y == $past(b)));

  // R6
  p_add_sum_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD) |=> ({co, y} == ({1'b0, $past(a)} + {1'b0, $past(b)})));

  // R8
  p_sub_borrow_r8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB) |=> (co == ($past(b) >= $past(a))));

endmodule

// File: tb/sim_alu_bs_top.sv
module sim_alu_bs_top;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic [3:0]   op  = '0;
  logic [W-1:0] y;
  logic         co;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  alu_bs_top #(.WIDTH(W)) u0 (
    .clk (clk), .rst (rst), .a (a), .b (b), .op (op), .y (y), .co (co)
  );

  function automatic logic [W:0] model(logic [W-1:0] fa, logic [W-1:0] fb, logic [3:0] fop);
    logic [W:0] r;
    case (fop)
      4'd0: r = {1'b0, fa & fb};
      4'd1: r = {1'b0, fa | fb};
      4'd2: r = {1'b0, fa ^ fb};
      4'd3: r = {1'b0, fa} + {1'b0, fb};
      4'd4: r = {1'b0, fa} + {1'b0, fb} + 1;
      4'd5: r = {(fb >= fa), fb - fa};
      4'd6: r = {1'b0, fb};
      4'd7: r = {1'b0, ~fa};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [3:0] fop);
    case (fop)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5: return "R8";
      4'd6: return "R9";
      4'd7: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [W:0] got, logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got co=%0b y=%h, expected co=%0b y=%h", tag, got[W], got[W-1:0], exp[W], exp[W-1:0]);
    end
  endtask

  task automatic run_op(string tag, logic [W-1:0] ta, logic [W-1:0] tb_, logic [3:0] top_);
    @(negedge clk);
    a = ta; b = tb_; op = top_;
    @(posedge clk);
    #1;
    check(tag, {co, y}, model(ta, tb_, top_));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W:0] held;
    void'($urandom(32'd1234));
    // R1: reset clears even with a nonzero operation present
    a = 4'hF; b = 4'hF; op = 4'd3; rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {co, y}, '0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R6", {co, y}, model(4'hF, 4'hF, 4'd3));
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1", {co, y}, '0);
    @(negedge clk);
    rst = 1'b0;

    // R2: one-cycle latency, output holds until the edge
    run_op("R2", 4'h3, 4'h5, 4'd3);
    held = {co, y};
    @(negedge clk);
    a = 4'hA; b = 4'h6; op = 4'd1;
    #1.5;
    check("R2", {co, y}, held);
    @(posedge clk); #1;
    check("R2", {co, y}, model(4'hA, 4'h6, 4'd1));

    // directed corners
    run_op("R3", 4'hC, 4'hA, 4'd0);
    run_op("R4", 4'hC, 4'hA, 4'd1);
    run_op("R5", 4'hC, 4'hA, 4'd2);
    run_op("R12", 4'hF, 4'h1, 4'd3);
    check("R12", {co, y}, {1'b1, 4'h0});
    run_op("R7", 4'hF, 4'h0, 4'd4);
    run_op("R7", 4'h7, 4'h7, 4'd4);
    run_op("R8", 4'h5, 4'h5, 4'd5);
    run_op("R8", 4'h6, 4'h2, 4'd5);
    run_op("R8", 4'h0, 4'hF, 4'd5);
    run_op("R9", 4'hF, 4'h9, 4'd6);
    run_op("R10", 4'h6, 4'hF, 4'd7);
    run_op("R11", 4'hF, 4'hF, 4'd8);
    run_op("R11", 4'hF, 4'hF, 4'd15);

    // random sweep over all codes
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      logic [3:0]   ro;
      ra = W'($urandom);
      rb = W'($urandom);
      ro = 4'($urandom);
      run_op(tag_of(ro), ra, rb, ro);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule